// File: doc/BRIEF.md
# Dual-Modulus Divide-by-Two-or-Three Cell

This cell divides its input clock by two or by three, and it picks the ratio again for each output period. Two state flops and a small AND-based feedback network form the loop. In the longer mode the loop passes through one extra state, so it absorbs one more input cycle.

A period of three cycles happens only when two inputs are high together. One is the modulus-control input, which the next, slower cell drives. The other is the cell's static program bit. The cell also drives a registered modulus-control output towards the previous, faster cell. Cells can therefore be chained into a programmable loop in which each cell adds at most one cycle per output period of the last cell.

Each output period starts with a single low input cycle on `div_out`. The modulus is sampled only on the rising edge that ends that low cycle. A change on either mode input during the rest of the period therefore never cuts a period short and never stretches it.

Top module: `div23_cell`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `div_out` = 1 and `mod_out` = 0. The first rising edge after `rst` falls drives `div_out` low, and this starts an output period.
- R2: When `mod_in` = 1 and `prog_en` = 1 at the sampling edge, the output period is 3 input cycles: `div_out` is low for 1 cycle and then high for 2.
- R3: When `mod_in` = 0 at the sampling edge, the output period is 2 input cycles: `div_out` is low for 1 cycle and then high for 1, whatever the value of `prog_en`.
- R4: When `prog_en` = 0 at the sampling edge, the output period is 2 input cycles even when `mod_in` = 1.
- R5: The low phase of `div_out` always lasts exactly one input cycle, and `div_out` changes only on rising edges of `clk`.
- R6: The modulus is sampled only at the rising edge that ends the low cycle of `div_out`. A change on `mod_in` or `prog_en` after that edge does not alter the length of the current period.
- R7: `mod_out` is high for exactly the low cycle of `div_out`, and only when `mod_in` was 1 at the edge that started that low cycle. At every other time it is 0.
- R8: `mod_out` does not depend on `prog_en`. With `prog_en` = 0 and `mod_in` = 1, `mod_out` still pulses once per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided; every flop uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mod_in | input | 1 | Modulus control from the following cell |
| prog_en | input | 1 | Static program bit; when high, the cell may swallow one extra input cycle |
| div_out | output | 1 | Divided clock towards the following cell; its falling edge starts each period |
| mod_out | output | 1 | Modulus control towards the preceding cell |

## Verification
A flop stuck in a wrong value shows up within one output period as a wrong period length, or as a `div_out` low phase longer than one cycle. An illegal state with both flops low recovers on the next edge, but that edge gives a shortened period. A wrong gating term changes the next period after the sampling edge, at most three cycles later. A misplaced `mod_out` pulse shows in the very cycle `div_out` goes low. For this reason the bench measures period lengths edge by edge and checks `mod_out` in every cycle of a period.

// File: rtl/div23_pkg.sv
package div23_pkg;
  typedef struct packed {
    logic q1;
    logic q2;
  } div23_state_t;

  localparam int unsigned STATE_BITS = 2;
  // state held by reset: the tail of a period, so the next edge starts one
  localparam div23_state_t RESET_STATE = '{q1: 1'b1, q2: 1'b1};
endpackage

// File: rtl/div23_flop.sv
module div23_flop #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/div23_gating.sv
module div23_gating
  import div23_pkg::*;
(
  input  div23_state_t cur,
  input  logic         mod_in,
  input  logic         prog_en,
  output div23_state_t nxt,
  output logic         mod_set
);
  logic swallow;

  always_comb begin
    // the extra cycle needs both the modulus request and the program bit
    swallow = mod_in & prog_en;
    // the first flop leaves 1 only from the low state, and only when swallowing
    nxt.q1  = cur.q2 | ~swallow;
    // the second flop inverts through the AND of both state bits
    nxt.q2  = ~(cur.q1 & cur.q2);
    // the next edge enters the low state; pass the request back upstream
    mod_set = cur.q1 & cur.q2 & mod_in;
  end
endmodule

// File: rtl/div23_cell.sv
module div23_cell
  import div23_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mod_in,
  input  logic prog_en,
  output logic div_out,
  output logic mod_out
);
  div23_state_t            st_q;
  div23_state_t            st_d;
  logic [STATE_BITS-1:0]   st_q_vec;
  logic [STATE_BITS-1:0]   st_d_vec;
  logic [STATE_BITS-1:0]   rst_vec;
  logic                    mod_set;
  logic                    q1_w;
  logic                    q2_w;

  assign st_d_vec = st_d;
  assign rst_vec  = RESET_STATE;
  assign st_q     = st_q_vec;
  assign q1_w     = st_q.q1;
  assign q2_w     = st_q.q2;

  div23_gating u_gate (
    .cur     (st_q),
    .mod_in  (mod_in),
    .prog_en (prog_en),
    .nxt     (st_d),
    .mod_set (mod_set)
  );

  for (genvar i = 0; i < STATE_BITS; i++) begin : g_state
    div23_flop #(.RST_VAL(RESET_STATE[i])) u_ff (
      .clk (clk),
      .rst (rst),
      .d   (st_d_vec[i]),
      .q   (st_q_vec[i])
    );
  end

  div23_flop #(.RST_VAL(1'b0)) u_mod_ff (
    .clk (clk),
    .rst (rst),
    .d   (mod_set),
    .q   (mod_out)
  );

  assign div_out = q2_w;

  logic unused_rst_vec;
  assign unused_rst_vec = ^rst_vec;
endmodule

// File: rtl/div23_cell_chk.sv
module div23_cell_chk (
  input logic clk,
  input logic rst,
  input logic mod_in,
  input logic prog_en,
  input logic div_out,
  input logic mod_out,
  input logic q1
);
  AST_RESET_LEVELS: assert property (@(posedge clk) rst |=> (div_out && !mod_out)); // R1
  AST_DIV3_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!div_out && mod_in && prog_en) |=> (div_out && !q1)); // R2
  AST_DIV2_NOMOD: assert property (@(posedge clk) disable iff (rst)
    (!div_out && !mod_in) |=> (div_out && q1)); // R3
  AST_DIV2_NOPROG: assert property (@(posedge clk) disable iff (rst)
    (!div_out && !prog_en) |=> (div_out && q1)); // R4
  AST_LOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !div_out |=> div_out); // R5
  AST_FALL_FROM_TAIL: assert property (@(posedge clk) disable iff (rst)
    (div_out && !q1) |=> div_out); // R6
  AST_MOD_IN_LOW: assert property (@(posedge clk) disable iff (rst)
    mod_out |-> !div_out); // R7
  AST_MOD_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_out) |-> $past(mod_in)); // R8
endmodule

bind div23_cell div23_cell_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .mod_in  (mod_in),
  .prog_en (prog_en),
  .div_out (div_out),
  .mod_out (mod_out),
  .q1      (q1_w)
);

// File: tb/div23_cell_bench.sv
module div23_cell_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_in = 1'b0;
  logic prog_en = 1'b0;
  logic div_out;
  logic mod_out;
  int   checks = 0;
  int   errors = 0;

  always #4 clk = ~clk;

  div23_cell u_div23_cell (
    .clk     (clk),
    .rst     (rst),
    .mod_in  (mod_in),
    .prog_en (prog_en),
    .div_out (div_out),
    .mod_out (mod_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Entered at a negedge inside the low cycle; leaves at the next low cycle.
  task automatic run_period(input logic mi, input logic pb, input int exp_len, input string req);
    int len;
    int high_mod;
    mod_in  = mi;
    prog_en = pb;
    len      = 0;
    high_mod = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      len++;
      if (!div_out) break;
      if (mod_out) high_mod++;
    end
    check({req, " period length"}, len, exp_len);
    check({req, " R7 mod_out quiet while high"}, high_mod, 0);
    check({req, " R7 mod_out in low cycle"}, int'(mod_out), int'(mi));
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R1 div_out in reset", int'(div_out), 1);
    check("R1 mod_out in reset", int'(mod_out), 0);
    rst     = 1'b0;
    mod_in  = 1'b1;
    prog_en = 1'b1;
    @(negedge clk);
    check("R1 first edge drives low", int'(div_out), 0);
    check("R1 R7 mod_out with first low", int'(mod_out), 1);
  endtask

  task automatic test_div3();
    for (int p = 0; p < 3; p++) run_period(1'b1, 1'b1, 3, "R2");
  endtask

  task automatic test_div2_nomod();
    run_period(1'b0, 1'b1, 2, "R3 prog=1");
    run_period(1'b0, 1'b0, 2, "R3 prog=0");
  endtask

  task automatic test_div2_noprog();
    run_period(1'b1, 1'b0, 2, "R4 R8");
    run_period(1'b1, 1'b0, 2, "R4 R8 repeat");
  endtask

  task automatic test_low_phase();
    int lows;
    mod_in  = 1'b1;
    prog_en = 1'b1;
    lows    = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (!div_out) lows++;
      if (!div_out) begin
        @(negedge clk);
        check("R5 low lasts one cycle", int'(div_out), 1);
      end
    end
    check("R5 low count in window", (lows >= 3) ? 1 : 0, 1);
    // realign to a low cycle
    for (int k = 0; k < 4; k++) begin
      if (!div_out) break;
      @(negedge clk);
    end
  endtask

  task automatic test_mid_change();
    int len;
    mod_in  = 1'b1;
    prog_en = 1'b1;
    @(negedge clk);
    len = 1;
    prog_en = 1'b0;
    mod_in  = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      len++;
      if (!div_out) break;
    end
    check("R6 late change keeps period", len, 3);
    check("R6 R7 mod_out after late drop", int'(mod_out), 0);
    run_period(1'b0, 1'b0, 2, "R6 next period follows");
    // rise late in a short period: no stretch
    mod_in  = 1'b0;
    prog_en = 1'b0;
    @(negedge clk);
    mod_in  = 1'b1;
    prog_en = 1'b1;
    @(negedge clk);
    check("R6 late rise no stretch", int'(div_out), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_div3();
    test_div2_nomod();
    test_div2_noprog();
    test_low_phase();
    test_mid_change();
    run_period(1'b1, 1'b1, 3, "R2 after mixed");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule